// File: doc/BRIEF.md
# Multicycle processor control state machine

This block is the hardwired sequencer for a 32-bit load/store processor whose datapath shares a single ALU, a single memory port and a handful of holding registers (instruction register, memory data register, A, B, ALUOut) across several clock cycles. Every instruction begins with a fetch step and a decode step. The controller then walks through a short, opcode-specific sequence and comes back to fetch. In each step it drives the datapath's write enables and multiplexer selects.

The controller takes two inputs: the 6-bit opcode, held in the instruction register from decode onward, and the ALU zero flag. The supported operations are word load, word store, register-register arithmetic (the ALU decodes the funct field itself), branch-if-equal and absolute jump. Any other opcode leads to an exception step. That step saves the address of the offending instruction (PC minus 4) into the exception PC register, loads the undefined-opcode code into the cause register and redirects the PC to the handler vector 0xC. The opcode values are parameters.

Top module: `mc_ctrl`

## Requirements
- R1: When rst_n is low at a rising clock edge, the controller is in the fetch step in the following cycle, whatever step it was in before.
- R2: Fetch asserts mem_rd, ir_wr and pc_wr. It drives mem_addr_sel=0 (PC), alu_a_sel=0 (PC), alu_b_sel=1 (constant 4), alu_op=0 (add) and pc_src_sel=0 (ALU result). The next step is always decode.
- R3: Decode asserts no write enable and drives alu_a_sel=0, alu_b_sel=3 (sign-extended immediate shifted left 2) and alu_op=0. The next step is chosen by opcode: 0x23 or 0x2B goes to address, 0x00 to execute, 0x04 to branch, 0x02 to jump, and any other value to exception.
- R4: The address step drives alu_a_sel=1 (A), alu_b_sel=2 (sign-extended immediate) and alu_op=0. It goes to memory-read if the opcode is 0x23 and to memory-write otherwise.
- R5: Memory-read asserts mem_rd with mem_addr_sel=1 (ALUOut). It is followed by one load write-back cycle: rf_wr=1, rf_dst_sel=0 (rt), rf_data_sel=1 (MDR). Fetch comes after that.
- R6: Memory-write asserts mem_wr with mem_addr_sel=1 and then returns to fetch.
- R7: Execute drives alu_a_sel=1, alu_b_sel=0 (B) and alu_op=2 (funct-selected). It is followed by one write-back cycle: rf_wr=1, rf_dst_sel=1 (rd), rf_data_sel=0 (ALUOut). Fetch comes after that.
- R8: Branch drives alu_a_sel=1, alu_b_sel=0, alu_op=1 (subtract), pc_src_sel=1 (ALUOut) and pc_wr_cond=1 with pc_wr=0. In this step pc_en equals alu_zero. The next step is fetch.
- R9: Jump asserts pc_wr with pc_src_sel=2 (upper PC bits joined with the jump field shifted left 2) and then returns to fetch.
- R10: Exception asserts epc_wr, cause_wr and pc_wr. It drives alu_a_sel=0, alu_b_sel=1, alu_op=1 (PC minus 4) and pc_src_sel=3 (vector 0xC), then returns to fetch.
- R11: A write enable (ir_wr, pc_wr, pc_wr_cond, mem_rd, mem_wr, rf_wr, epc_wr, cause_wr) is low in every step that does not name it. A select that a step does not name reads 0. pc_en equals pc_wr outside the branch step, so alu_zero has no effect there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC write request |
| pc_wr_cond | output | 1 | PC write request qualified by alu_zero |
| pc_en | output | 1 | Final PC load enable |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write of B |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| rf_wr | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Write register: 0 rt, 1 rd |
| rf_data_sel | output | 1 | Write data: 0 ALUOut, 1 MDR |
| alu_a_sel | output | 1 | ALU input A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU input B: 0 B, 1 four, 2 immediate, 3 immediate shifted |
| alu_op | output | 2 | 0 add, 1 subtract, 2 funct field |
| pc_src_sel | output | 2 | 0 ALU result, 1 ALUOut, 2 jump target, 3 vector 0xC |
| epc_wr | output | 1 | Exception PC register write |
| cause_wr | output | 1 | Cause register write (undefined-opcode code) |

## Verification
The bench builds the controller with the default opcode parameters (0x23, 0x2B, 0x00, 0x04, 0x02). This makes every dispatch branch reachable from plain opcode values, and any other value, for example 0x3F or 0x08, reaches the exception path. The bench drives alu_zero both ways during branch steps and toggles it in every other step, so a leak of the zero flag into pc_en outside branch would be visible. A reset applied in the middle of an R-type sequence shows that the step counter is overridden at any point.

// File: rtl/mc_ctrl_pkg.sv
// Package: step encoding, select encodings and the control bundle shared by
// the multicycle controller modules. Assumes a 4-bit step code is enough.
package mc_ctrl_pkg;

    localparam int STEP_W = 4;
    localparam int SEL2_W = 2;

    typedef enum logic [STEP_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDMEM  = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STMEM  = 4'd5,
        ST_EXEC   = 4'd6,
        ST_RWB    = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9,
        ST_EXCEPT = 4'd10
    } step_t;

    localparam logic              ASEL_PC    = 1'b0;
    localparam logic              ASEL_REG   = 1'b1;
    localparam logic [SEL2_W-1:0] BSEL_REG   = 2'd0;
    localparam logic [SEL2_W-1:0] BSEL_FOUR  = 2'd1;
    localparam logic [SEL2_W-1:0] BSEL_IMM   = 2'd2;
    localparam logic [SEL2_W-1:0] BSEL_IMMSH = 2'd3;
    localparam logic [SEL2_W-1:0] OP_ADD     = 2'd0;
    localparam logic [SEL2_W-1:0] OP_SUB     = 2'd1;
    localparam logic [SEL2_W-1:0] OP_FUNCT   = 2'd2;
    localparam logic [SEL2_W-1:0] PCS_ALU    = 2'd0;
    localparam logic [SEL2_W-1:0] PCS_ALUOUT = 2'd1;
    localparam logic [SEL2_W-1:0] PCS_JUMP   = 2'd2;
    localparam logic [SEL2_W-1:0] PCS_VECTOR = 2'd3;

    typedef struct packed {
        logic              ir_wr;
        logic              pc_wr;
        logic              pc_wr_cond;
        logic              mem_rd;
        logic              mem_wr;
        logic              mem_addr_sel;
        logic              rf_wr;
        logic              rf_dst_sel;
        logic              rf_data_sel;
        logic              alu_a_sel;
        logic [SEL2_W-1:0] alu_b_sel;
        logic [SEL2_W-1:0] alu_op;
        logic [SEL2_W-1:0] pc_src_sel;
        logic              epc_wr;
        logic              cause_wr;
    } ctrl_t;

endpackage

// File: rtl/mc_ctrl_state.sv
// Step register of the controller. Holds the current step and loads the
// fetch step on a synchronous active-low reset. Assumes the next step
// arrives already decoded.
module mc_ctrl_state
    import mc_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  step_t step_d,
    output step_t step_q
);

    // Step register with synchronous reset to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_FETCH;
        end else begin
            step_q <= step_d;
        end
    end

    AST_RESET_FETCH: assert property (@(posedge clk) !rst_n |=> step_q == ST_FETCH); // R1

endmodule

// File: rtl/mc_ctrl_next.sv
// Next-step logic. Fixed successors for most steps, plus two opcode
// dispatches: one after decode and one after the address step. Assumes the
// opcode stays stable from decode until the instruction completes.
module mc_ctrl_next
    import mc_ctrl_pkg::*;
#(
    parameter int                 OPC_W     = 6,
    parameter logic [OPC_W-1:0]   OPC_LOAD  = 6'h23,
    parameter logic [OPC_W-1:0]   OPC_STORE = 6'h2B,
    parameter logic [OPC_W-1:0]   OPC_RTYPE = 6'h00,
    parameter logic [OPC_W-1:0]   OPC_BEQ   = 6'h04,
    parameter logic [OPC_W-1:0]   OPC_JUMP  = 6'h02
) (
    input  step_t            step_i,
    input  logic [OPC_W-1:0] opcode_i,
    output step_t            step_o
);

    step_t decode_target;

    // First dispatch: choose the sequence for the decoded opcode.
    always_comb begin
        if (opcode_i == OPC_LOAD || opcode_i == OPC_STORE) begin
            decode_target = ST_ADDR;
        end else if (opcode_i == OPC_RTYPE) begin
            decode_target = ST_EXEC;
        end else if (opcode_i == OPC_BEQ) begin
            decode_target = ST_BRANCH;
        end else if (opcode_i == OPC_JUMP) begin
            decode_target = ST_JUMP;
        end else begin
            decode_target = ST_EXCEPT;
        end
    end

    // Successor of each step; the second dispatch splits load from store.
    always_comb begin
        case (step_i)
            ST_FETCH:  step_o = ST_DECODE;
            ST_DECODE: step_o = decode_target;
            ST_ADDR:   step_o = (opcode_i == OPC_LOAD) ? ST_LDMEM : ST_STMEM;
            ST_LDMEM:  step_o = ST_LDWB;
            ST_EXEC:   step_o = ST_RWB;
            default:   step_o = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_outdec.sv
// Output decode. Maps the current step to the datapath control bundle and
// qualifies the conditional PC write with the zero flag. Assumes unused
// selects should read 0 and that every write enable defaults to off.
module mc_ctrl_outdec
    import mc_ctrl_pkg::*;
(
    input  step_t step_i,
    input  logic  zero_i,
    output ctrl_t ctrl_o,
    output logic  pc_en_o
);

    // Per-step control values, all fields cleared first.
    always_comb begin
        ctrl_o = '0;
        case (step_i)
            ST_FETCH: begin
                ctrl_o.mem_rd     = 1'b1;
                ctrl_o.ir_wr      = 1'b1;
                ctrl_o.pc_wr      = 1'b1;
                ctrl_o.alu_a_sel  = ASEL_PC;
                ctrl_o.alu_b_sel  = BSEL_FOUR;
                ctrl_o.alu_op     = OP_ADD;
                ctrl_o.pc_src_sel = PCS_ALU;
            end
            ST_DECODE: begin
                ctrl_o.alu_a_sel  = ASEL_PC;
                ctrl_o.alu_b_sel  = BSEL_IMMSH;
                ctrl_o.alu_op     = OP_ADD;
            end
            ST_ADDR: begin
                ctrl_o.alu_a_sel  = ASEL_REG;
                ctrl_o.alu_b_sel  = BSEL_IMM;
                ctrl_o.alu_op     = OP_ADD;
            end
            ST_LDMEM: begin
                ctrl_o.mem_rd       = 1'b1;
                ctrl_o.mem_addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctrl_o.rf_wr       = 1'b1;
                ctrl_o.rf_dst_sel  = 1'b0;
                ctrl_o.rf_data_sel = 1'b1;
            end
            ST_STMEM: begin
                ctrl_o.mem_wr       = 1'b1;
                ctrl_o.mem_addr_sel = 1'b1;
            end
            ST_EXEC: begin
                ctrl_o.alu_a_sel  = ASEL_REG;
                ctrl_o.alu_b_sel  = BSEL_REG;
                ctrl_o.alu_op     = OP_FUNCT;
            end
            ST_RWB: begin
                ctrl_o.rf_wr       = 1'b1;
                ctrl_o.rf_dst_sel  = 1'b1;
                ctrl_o.rf_data_sel = 1'b0;
            end
            ST_BRANCH: begin
                ctrl_o.alu_a_sel  = ASEL_REG;
                ctrl_o.alu_b_sel  = BSEL_REG;
                ctrl_o.alu_op     = OP_SUB;
                ctrl_o.pc_src_sel = PCS_ALUOUT;
                ctrl_o.pc_wr_cond = 1'b1;
            end
            ST_JUMP: begin
                ctrl_o.pc_wr      = 1'b1;
                ctrl_o.pc_src_sel = PCS_JUMP;
            end
            ST_EXCEPT: begin
                ctrl_o.alu_a_sel  = ASEL_PC;
                ctrl_o.alu_b_sel  = BSEL_FOUR;
                ctrl_o.alu_op     = OP_SUB;
                ctrl_o.epc_wr     = 1'b1;
                ctrl_o.cause_wr   = 1'b1;
                ctrl_o.pc_wr      = 1'b1;
                ctrl_o.pc_src_sel = PCS_VECTOR;
            end
            default: ctrl_o = '0;
        endcase
    end

    // Final PC enable: unconditional request or zero-qualified request.
    always_comb begin
        pc_en_o = ctrl_o.pc_wr | (ctrl_o.pc_wr_cond & zero_i);
    end

endmodule

// File: rtl/mc_ctrl.sv
// Multicycle processor controller top. Joins the step register, the
// next-step logic and the output decode, and exposes the control bundle as
// plain ports. Assumes opcode comes from the instruction register and stays
// stable from decode onward.
module mc_ctrl
    import mc_ctrl_pkg::*;
#(
    parameter int                 OPC_W     = 6,
    parameter logic [OPC_W-1:0]   OPC_LOAD  = 6'h23,
    parameter logic [OPC_W-1:0]   OPC_STORE = 6'h2B,
    parameter logic [OPC_W-1:0]   OPC_RTYPE = 6'h00,
    parameter logic [OPC_W-1:0]   OPC_BEQ   = 6'h04,
    parameter logic [OPC_W-1:0]   OPC_JUMP  = 6'h02
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_zero,
    output logic             ir_wr,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             pc_en,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             mem_addr_sel,
    output logic             rf_wr,
    output logic             rf_dst_sel,
    output logic             rf_data_sel,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic [1:0]       alu_op,
    output logic [1:0]       pc_src_sel,
    output logic             epc_wr,
    output logic             cause_wr
);

    step_t step_q;
    step_t step_d;
    ctrl_t ctrl;

    mc_ctrl_state u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_d (step_d),
        .step_q (step_q)
    );

    mc_ctrl_next #(
        .OPC_W     (OPC_W),
        .OPC_LOAD  (OPC_LOAD),
        .OPC_STORE (OPC_STORE),
        .OPC_RTYPE (OPC_RTYPE),
        .OPC_BEQ   (OPC_BEQ),
        .OPC_JUMP  (OPC_JUMP)
    ) u_next (
        .step_i   (step_q),
        .opcode_i (opcode),
        .step_o   (step_d)
    );

    mc_ctrl_outdec u_outdec (
        .step_i  (step_q),
        .zero_i  (alu_zero),
        .ctrl_o  (ctrl),
        .pc_en_o (pc_en)
    );

    // Unpack the control bundle onto the ports.
    always_comb begin
        ir_wr        = ctrl.ir_wr;
        pc_wr        = ctrl.pc_wr;
        pc_wr_cond   = ctrl.pc_wr_cond;
        mem_rd       = ctrl.mem_rd;
        mem_wr       = ctrl.mem_wr;
        mem_addr_sel = ctrl.mem_addr_sel;
        rf_wr        = ctrl.rf_wr;
        rf_dst_sel   = ctrl.rf_dst_sel;
        rf_data_sel  = ctrl.rf_data_sel;
        alu_a_sel    = ctrl.alu_a_sel;
        alu_b_sel    = ctrl.alu_b_sel;
        alu_op       = ctrl.alu_op;
        pc_src_sel   = ctrl.pc_src_sel;
        epc_wr       = ctrl.epc_wr;
        cause_wr     = ctrl.cause_wr;
    end

    logic opc_known;

    // Opcode recognised by the first dispatch (used only by the checks below).
    always_comb begin
        opc_known = (opcode == OPC_LOAD) || (opcode == OPC_STORE) ||
                    (opcode == OPC_RTYPE) || (opcode == OPC_BEQ) ||
                    (opcode == OPC_JUMP);
    end

    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        step_q == ST_FETCH |=> step_q == ST_DECODE); // R2
    AST_IR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> !ir_wr); // R2
    AST_UNDEF_TO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_DECODE && !opc_known) |=> (epc_wr && cause_wr)); // R3
    AST_LOAD_READ_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_addr_sel) |=> (rf_wr && rf_data_sel && !rf_dst_sel)); // R5
    AST_RF_WR_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |=> ir_wr); // R7
    AST_STORE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ir_wr); // R6
    AST_BRANCH_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |=> ir_wr); // R8
    AST_EXC_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        epc_wr |=> ir_wr); // R10
    AST_WRITES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ir_wr, mem_wr, rf_wr, epc_wr, pc_wr_cond})); // R11

endmodule

// File: tb/mc_ctrl_tb.sv
// Bench for mc_ctrl: a behavioural step model, compared with every port on every cycle.
module mc_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;
    logic ir_wr, pc_wr, pc_wr_cond, pc_en, mem_rd, mem_wr, mem_addr_sel;
    logic rf_wr, rf_dst_sel, rf_data_sel, alu_a_sel, epc_wr, cause_wr;
    logic [1:0] alu_b_sel, alu_op, pc_src_sel;

    int checks = 0;
    int failures = 0;
    int mstate = 0;
    bit after_reset = 1'b1;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .ir_wr(ir_wr), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_en(pc_en),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr_sel(mem_addr_sel),
        .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel), .rf_data_sel(rf_data_sel),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .pc_src_sel(pc_src_sel), .epc_wr(epc_wr), .cause_wr(cause_wr)
    );

    // Model step numbers: 0 fetch,1 decode,2 addr,3 ld mem,4 ld wb,5 st mem,
    // 6 exec,7 r wb,8 branch,9 jump,10 exception.
    function automatic int model_next(int s, logic [5:0] op);
        case (s)
            0: return 1;
            1: begin
                if (op == 6'h23 || op == 6'h2B) return 2;
                if (op == 6'h00) return 6;
                if (op == 6'h04) return 8;
                if (op == 6'h02) return 9;
                return 10;
            end
            2: return (op == 6'h23) ? 3 : 5;
            3: return 4;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    // Expected port vector:
    // {ir,pcw,pcc,pcen,mrd,mwr,asel_mem,rfw,dst,data,a,b[2],op[2],pcs[2],epc,cause}
    function automatic logic [18:0] model_out(int s, logic z);
        logic ir, pw, pc, mr, mw, ma, rw, rd, rdat, a, ep, ca;
        logic [1:0] b, op, ps;
        {ir, pw, pc, mr, mw, ma, rw, rd, rdat, a, ep, ca} = '0;
        b = 0; op = 0; ps = 0;
        case (s)
            0: begin mr = 1; ir = 1; pw = 1; b = 1; end
            1: begin b = 3; end
            2: begin a = 1; b = 2; end
            3: begin mr = 1; ma = 1; end
            4: begin rw = 1; rdat = 1; end
            5: begin mw = 1; ma = 1; end
            6: begin a = 1; op = 2; end
            7: begin rw = 1; rd = 1; end
            8: begin a = 1; op = 1; ps = 1; pc = 1; end
            9: begin pw = 1; ps = 2; end
            10: begin op = 1; b = 1; ep = 1; ca = 1; pw = 1; ps = 3; end
            default: ;
        endcase
        return {ir, pw, pc, pw | (pc & z), mr, mw, ma, rw, rd, rdat, a, b, op, ps, ep, ca};
    endfunction

    function automatic string req_of(int s);
        case (s)
            0: return "R2/R11";
            1: return "R3/R11";
            2: return "R4/R11";
            3, 4: return "R5/R11";
            5: return "R6/R11";
            6, 7: return "R7/R11";
            8: return "R8/R11";
            9: return "R9/R11";
            default: return "R10/R11";
        endcase
    endfunction

    // Model step update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) mstate <= 0;
        else mstate <= model_next(mstate, opcode);
        after_reset <= !rst_n;
    end

    logic [5:0] prog_op [0:13] = '{6'h23, 6'h2B, 6'h00, 6'h04, 6'h04, 6'h02,
                                   6'h3F, 6'h08, 6'h00, 6'h23, 6'h01, 6'h2B, 6'h04, 6'h00};
    bit         prog_z  [0:13] = '{0, 1, 0, 1, 0, 1, 0, 1, 1, 0, 0, 1, 0, 1};

    initial begin
        int idx;
        bit cur_z;
        logic [18:0] got, exp;
        idx = 0;
        cur_z = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        while (!done) begin
            if (mstate == 0 && !after_reset && idx == 14) begin
                done = 1'b1;
            end else begin
                if (mstate == 0 && idx < 14) begin
                    opcode = prog_op[idx];
                    cur_z = prog_z[idx];
                    idx++;
                end
                if (mstate == 8) alu_zero = cur_z;
                else alu_zero = ~alu_zero;
                #1;
                got = {ir_wr, pc_wr, pc_wr_cond, pc_en, mem_rd, mem_wr, mem_addr_sel,
                       rf_wr, rf_dst_sel, rf_data_sel, alu_a_sel, alu_b_sel, alu_op,
                       pc_src_sel, epc_wr, cause_wr};
                exp = model_out(mstate, alu_zero);
                checks++;
                if (got !== exp) begin
                    failures++;
                    $display("FAIL %s step=%0d actual=%b expected=%b",
                             after_reset ? "R1" : req_of(mstate), mstate, got, exp);
                end
                // Mid-instruction reset during the second R-type execute step (R1).
                if (idx == 9 && mstate == 6) rst_n = 1'b0;
                else rst_n = 1'b1;
                @(negedge clk);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule